// File: doc/BRIEF.md
# Delay-Slot Next-PC Sequencer

This block holds the fetch address state of a 32-bit core that always executes one instruction after every control transfer. It keeps three addresses: the instruction being retired now (`pc_o`), the instruction in the delay slot after it (`npc_o`), and the address that follows (`nnpc_o`). Every valid step it takes a decoded description of the instruction at `pc_o` and moves the three registers forward. The description gives the control class, the link and likely flags, the immediate fields, the resolved condition and a register operand. When the instruction is a taken branch or a jump, the address after the delay slot is replaced by the target.

Branches are PC-relative. Their displacement is the 16-bit offset multiplied by four and sign-extended. Register jumps keep bit 0 of the sequential address as a mode bit. Absolute jumps keep the upper address region of the sequential address.

A likely branch that is not taken drops its delay-slot instruction. Execution resumes at the address after the slot, and a one-step annul strobe is raised. A linking transfer reports the return address, which is the address after the delay slot, on a one-step write strobe meant for the register file.

Top module: `npc_seq_unit`

## Requirements
- R1: While `rst_i` is high at a clock edge, the state becomes `pc_o` = RESET_VEC, `npc_o` = RESET_VEC+4 and `nnpc_o` = RESET_VEC+8, with `link_we_o` and `annul_o` low.
- R2: A valid step of class 0 (none) moves the state as follows: `pc_o` takes the old `npc_o`, `npc_o` takes the old `nnpc_o`, and `nnpc_o` takes the old `nnpc_o`+4. Class codes 5 to 7 behave as class 0.
- R3: A step with `step_valid_i` low leaves all three addresses unchanged and drives `link_we_o` and `annul_o` low, whatever the other inputs are.
- R4: For a taken class 1 (conditional branch), the displacement D is `br_off_i` shifted left by 2 and sign-extended from bit 17. The new state is `pc_o` = old `npc_o`, `npc_o` = old `npc_o`+D, and `nnpc_o` = that target plus 4.
- R5: A class 1 branch with `cond_true_i` low and `likely_en_i` low moves the state as in R2, and `annul_o` stays low.
- R6: Class 2 (unconditional branch) always takes the R4 target, whatever the value of `cond_true_i`.
- R7: A class 1 branch with `likely_en_i` high and `cond_true_i` low skips the delay slot. The new state is `pc_o` = old `nnpc_o`, `npc_o` = old `nnpc_o`+4, `nnpc_o` = old `nnpc_o`+8, and `annul_o` is high for that step only. A taken likely branch behaves as in R4 with `annul_o` low.
- R8: Class 3 (register jump) is unconditional. Its target is `reg_val_i` with bits 1:0 cleared, ORed with bit 0 of (old `pc_o`+4). The target enters `npc_o` as in R4.
- R9: Class 4 (absolute jump) is unconditional. Its target is bits 31:28 of (old `pc_o`+4), followed by `jmp_field_i`, followed by two zero bits.
- R10: A valid step of class 1 to 4 with `link_en_i` high raises `link_we_o` for one step, with `link_val_o` equal to the old `nnpc_o`. This happens whether or not the branch is taken. Class 0 never raises `link_we_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| step_valid_i | input | 1 | Advance the sequence this cycle |
| ctl_kind_i | input | 3 | Control class: 0 none, 1 cond branch, 2 uncond branch, 3 register jump, 4 absolute jump |
| link_en_i | input | 1 | Write the return address |
| likely_en_i | input | 1 | Annul the delay slot if the branch is not taken |
| br_off_i | input | 16 | Branch word offset |
| jmp_field_i | input | 26 | Absolute jump word index |
| cond_true_i | input | 1 | Resolved branch condition |
| reg_val_i | input | 32 | Register operand for register jumps |
| pc_o | output | 32 | Address of the instruction being retired |
| npc_o | output | 32 | Delay-slot address |
| nnpc_o | output | 32 | Address after the delay slot |
| link_we_o | output | 1 | Return-address write strobe |
| link_val_o | output | 32 | Return address |
| annul_o | output | 1 | Delay slot dropped this step |

## Verification
All three address registers are output ports, so a wrong target or a wrong sequential increment shows up on `npc_o` or `nnpc_o` in the cycle after the step that caused it. The same error then moves into `pc_o` over the next one or two steps. A wrong choice between taking the branch and skipping the slot shows in the same cycle, because `pc_o` does not equal the old `npc_o` and the annul strobe has the wrong level. The bench compares all outputs to a behavioural model on every step, so the first wrong cycle is the one reported.

// File: rtl/npc_seq_pkg.sv
package npc_seq_pkg;

    typedef enum logic [2:0] {
        CK_NONE = 3'd0,
        CK_CBR  = 3'd1,
        CK_UBR  = 3'd2,
        CK_RJMP = 3'd3,
        CK_AJMP = 3'd4
    } ctl_kind_e;

endpackage

// File: rtl/npc_disp_ext.sv
module npc_disp_ext #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int ALIGN = 2
) (
    input  logic [OFF_W-1:0] off_i,
    output logic [XLEN-1:0]  disp_o
);
    localparam int EXT_W = XLEN - OFF_W - ALIGN;

    // word offset scaled to bytes, sign carried from the top offset bit
    always_comb begin
        disp_o = {{EXT_W{off_i[OFF_W-1]}}, off_i, {ALIGN{1'b0}}};
    end
endmodule

// File: rtl/npc_target_sel.sv
module npc_target_sel
    import npc_seq_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int JF_W  = 26,
    parameter int ALIGN = 2,
    parameter int STEP  = 4
) (
    input  ctl_kind_e       kind_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] npc_i,
    input  logic [XLEN-1:0] disp_i,
    input  logic [XLEN-1:0] reg_val_i,
    input  logic [JF_W-1:0] jfield_i,
    output logic [XLEN-1:0] target_o
);
    localparam int HI_W = XLEN - JF_W - ALIGN;
    localparam logic [XLEN-1:0] STEP_V   = XLEN'(STEP);
    localparam logic [XLEN-1:0] LOW_MASK = XLEN'((1 << ALIGN) - 1);
    localparam logic [XLEN-1:0] MODE_BIT = XLEN'(1);

    logic [XLEN-1:0] seq_addr;
    logic [XLEN-1:0] rel_tgt;
    logic [XLEN-1:0] reg_tgt;
    logic [XLEN-1:0] abs_tgt;

    always_comb begin
        seq_addr = pc_i + STEP_V;
        rel_tgt  = npc_i + disp_i;
        reg_tgt  = (reg_val_i & ~LOW_MASK) | (seq_addr & MODE_BIT);
        abs_tgt  = {seq_addr[XLEN-1 -: HI_W], jfield_i, {ALIGN{1'b0}}};
        case (kind_i)
            CK_RJMP: target_o = reg_tgt;
            CK_AJMP: target_o = abs_tgt;
            default: target_o = rel_tgt;
        endcase
    end
endmodule

// File: rtl/npc_flow_ctl.sv
module npc_flow_ctl
    import npc_seq_pkg::*;
(
    input  ctl_kind_e kind_i,
    input  logic      cond_i,
    input  logic      likely_i,
    input  logic      link_i,
    output logic      redirect_o,
    output logic      skip_slot_o,
    output logic      link_hit_o
);
    always_comb begin
        redirect_o  = 1'b0;
        skip_slot_o = 1'b0;
        link_hit_o  = 1'b0;
        case (kind_i)
            CK_CBR: begin
                redirect_o  = cond_i;
                skip_slot_o = ~cond_i & likely_i;
                link_hit_o  = link_i;
            end
            CK_UBR, CK_RJMP, CK_AJMP: begin
                redirect_o = 1'b1;
                link_hit_o = link_i;
            end
            default: begin
                redirect_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/npc_seq_unit.sv
module npc_seq_unit
    import npc_seq_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              OFF_W     = 16,
    parameter int              JF_W      = 26,
    parameter int              KIND_W    = 3,
    parameter logic [XLEN-1:0] RESET_VEC = 32'hBFC0_0000
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              step_valid_i,
    input  logic [KIND_W-1:0] ctl_kind_i,
    input  logic              link_en_i,
    input  logic              likely_en_i,
    input  logic [OFF_W-1:0]  br_off_i,
    input  logic [JF_W-1:0]   jmp_field_i,
    input  logic              cond_true_i,
    input  logic [XLEN-1:0]   reg_val_i,
    output logic [XLEN-1:0]   pc_o,
    output logic [XLEN-1:0]   npc_o,
    output logic [XLEN-1:0]   nnpc_o,
    output logic              link_we_o,
    output logic [XLEN-1:0]   link_val_o,
    output logic              annul_o
);
    localparam int              ALIGN  = 2;
    localparam int              STEP   = 1 << ALIGN;
    localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] npc;
        logic [XLEN-1:0] nnpc;
        logic            link_we;
        logic [XLEN-1:0] link_val;
        logic            annul;
    } seq_state_t;

    localparam seq_state_t RST_STATE = '{
        pc:       RESET_VEC,
        npc:      RESET_VEC + STEP_V,
        nnpc:     RESET_VEC + STEP_V + STEP_V,
        link_we:  1'b0,
        link_val: '0,
        annul:    1'b0
    };

    seq_state_t st_d, st_q;

    ctl_kind_e       kind;
    logic [XLEN-1:0] disp;
    logic [XLEN-1:0] target;
    logic            redirect;
    logic            skip_slot;
    logic            link_hit;
    logic [XLEN-1:0] eff_npc;
    logic [XLEN-1:0] eff_nnpc;

    assign kind = ctl_kind_e'(ctl_kind_i);

    npc_disp_ext #(
        .XLEN  (XLEN),
        .OFF_W (OFF_W),
        .ALIGN (ALIGN)
    ) u_disp (
        .off_i  (br_off_i),
        .disp_o (disp)
    );

    npc_target_sel #(
        .XLEN  (XLEN),
        .JF_W  (JF_W),
        .ALIGN (ALIGN),
        .STEP  (STEP)
    ) u_tgt (
        .kind_i    (kind),
        .pc_i      (st_q.pc),
        .npc_i     (st_q.npc),
        .disp_i    (disp),
        .reg_val_i (reg_val_i),
        .jfield_i  (jmp_field_i),
        .target_o  (target)
    );

    npc_flow_ctl u_flow (
        .kind_i      (kind),
        .cond_i      (cond_true_i),
        .likely_i    (likely_en_i),
        .link_i      (link_en_i),
        .redirect_o  (redirect),
        .skip_slot_o (skip_slot),
        .link_hit_o  (link_hit)
    );

    // next-state computation
    always_comb begin
        st_d         = st_q;
        st_d.link_we = 1'b0;
        st_d.annul   = 1'b0;
        eff_npc      = st_q.npc;
        eff_nnpc     = st_q.nnpc;
        if (step_valid_i) begin
            if (redirect) begin
                eff_nnpc = target;
            end else if (skip_slot) begin
                eff_npc  = st_q.nnpc;
                eff_nnpc = st_q.nnpc + STEP_V;
            end
            st_d.pc    = eff_npc;
            st_d.npc   = eff_nnpc;
            st_d.nnpc  = eff_nnpc + STEP_V;
            st_d.annul = skip_slot;
            if (link_hit) begin
                st_d.link_we  = 1'b1;
                st_d.link_val = st_q.nnpc;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= RST_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o       = st_q.pc;
    assign npc_o      = st_q.npc;
    assign nnpc_o     = st_q.nnpc;
    assign link_we_o  = st_q.link_we;
    assign link_val_o = st_q.link_val;
    assign annul_o    = st_q.annul;
endmodule

// File: rtl/npc_seq_chk.sv
module npc_seq_chk #(
    parameter int              XLEN      = 32,
    parameter int              KIND_W    = 3,
    parameter logic [XLEN-1:0] RESET_VEC = 32'hBFC0_0000
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              step_valid_i,
    input logic [KIND_W-1:0] ctl_kind_i,
    input logic [XLEN-1:0]   pc_o,
    input logic [XLEN-1:0]   npc_o,
    input logic [XLEN-1:0]   nnpc_o,
    input logic              link_we_o,
    input logic [XLEN-1:0]   link_val_o,
    input logic              annul_o
);
    localparam logic [XLEN-1:0] INC = XLEN'(4);

    AST_RESET_LOAD: assert property (@(posedge clk_i)
        rst_i |=> (pc_o == RESET_VEC && npc_o == RESET_VEC + INC &&
                   nnpc_o == RESET_VEC + INC + INC && !link_we_o && !annul_o)); // R1

    AST_SEQ_GAP: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_valid_i && ctl_kind_i == '0) |=> (nnpc_o == npc_o + INC)); // R2

    AST_PC_FOLLOW: assert property (@(posedge clk_i) disable iff (rst_i)
        step_valid_i |=> (pc_o == $past(npc_o) || annul_o)); // R2

    AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !step_valid_i |=> ($stable(pc_o) && $stable(npc_o) && $stable(nnpc_o))); // R3

    AST_STALL_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        !step_valid_i |=> (!link_we_o && !annul_o)); // R3

    AST_SKIP_TARGET: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_valid_i ##1 annul_o) |-> (pc_o == $past(nnpc_o))); // R7

    AST_LINK_ADDR: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_valid_i ##1 link_we_o) |-> (link_val_o == $past(nnpc_o))); // R10

    AST_PLAIN_NO_LINK: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_valid_i && ctl_kind_i == '0) |=> (!link_we_o && !annul_o)); // R10
endmodule

bind npc_seq_unit npc_seq_chk #(
    .XLEN      (XLEN),
    .KIND_W    (KIND_W),
    .RESET_VEC (RESET_VEC)
) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .step_valid_i (step_valid_i),
    .ctl_kind_i   (ctl_kind_i),
    .pc_o         (pc_o),
    .npc_o        (npc_o),
    .nnpc_o       (nnpc_o),
    .link_we_o    (link_we_o),
    .link_val_o   (link_val_o),
    .annul_o      (annul_o)
);

// File: tb/tb_npc_seq_unit.sv
module tb_npc_seq_unit;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] VEC        = 32'hBFC0_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_valid = 1'b0;
    logic [2:0]  ctl_kind = '0;
    logic        link_en = 1'b0;
    logic        likely_en = 1'b0;
    logic [15:0] br_off = '0;
    logic [25:0] jmp_field = '0;
    logic        cond_true = 1'b0;
    logic [31:0] reg_val = '0;
    logic [31:0] pc_o, npc_o, nnpc_o, link_val_o;
    logic        link_we_o, annul_o;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_pc, m_npc, m_nnpc;

    always #(CLK_PERIOD/2) clk = ~clk;

    npc_seq_unit #(.RESET_VEC(VEC)) dut (
        .clk_i        (clk),
        .rst_i        (rst),
        .step_valid_i (step_valid),
        .ctl_kind_i   (ctl_kind),
        .link_en_i    (link_en),
        .likely_en_i  (likely_en),
        .br_off_i     (br_off),
        .jmp_field_i  (jmp_field),
        .cond_true_i  (cond_true),
        .reg_val_i    (reg_val),
        .pc_o         (pc_o),
        .npc_o        (npc_o),
        .nnpc_o       (nnpc_o),
        .link_we_o    (link_we_o),
        .link_val_o   (link_val_o),
        .annul_o      (annul_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic do_step(input logic v, input logic [2:0] k, input logic ln,
                           input logic lk, input logic [15:0] off,
                           input logic [25:0] jf, input logic c,
                           input logic [31:0] rv, input string tag);
        logic [31:0] disp, e_npc, e_nnpc, e_lv;
        logic        e_we, e_an;
        step_valid = v; ctl_kind = k; link_en = ln; likely_en = lk;
        br_off = off; jmp_field = jf; cond_true = c; reg_val = rv;
        e_we = 1'b0; e_an = 1'b0; e_lv = '0;
        if (v) begin
            disp   = {{14{off[15]}}, off, 2'b00};
            e_npc  = m_npc;
            e_nnpc = m_nnpc;
            case (k)
                3'd1: begin
                    if (c) e_nnpc = m_npc + disp;
                    else if (lk) begin
                        e_npc  = m_nnpc;
                        e_nnpc = m_nnpc + 32'd4;
                        e_an   = 1'b1;
                    end
                end
                3'd2: e_nnpc = m_npc + disp;
                3'd3: e_nnpc = (rv & ~32'd3) | ((m_pc + 32'd4) & 32'd1);
                3'd4: e_nnpc = ((m_pc + 32'd4) & 32'hF000_0000) | {4'b0, jf, 2'b00};
                default: ;
            endcase
            if (ln && k >= 3'd1 && k <= 3'd4) begin
                e_we = 1'b1;
                e_lv = m_nnpc;
            end
            m_pc   = e_npc;
            m_npc  = e_nnpc;
            m_nnpc = e_nnpc + 32'd4;
        end
        @(negedge clk);
        chk(tag, "pc", pc_o, m_pc);
        chk(tag, "npc", npc_o, m_npc);
        chk(tag, "nnpc", nnpc_o, m_nnpc);
        chk(tag, "link_we", {31'b0, link_we_o}, {31'b0, e_we});
        chk(tag, "annul", {31'b0, annul_o}, {31'b0, e_an});
        if (e_we) chk(tag, "link_val", link_val_o, e_lv);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset values
        chk("R1", "pc", pc_o, VEC);
        chk("R1", "npc", npc_o, VEC + 32'd4);
        chk("R1", "nnpc", nnpc_o, VEC + 32'd8);
        chk("R1", "strobes", {30'b0, link_we_o, annul_o}, 32'd0);
        m_pc = VEC; m_npc = VEC + 32'd4; m_nnpc = VEC + 32'd8;

        do_step(1, 3'd0, 0, 0, 16'h0000, 26'h0, 0, 32'h0, "R2");
        do_step(1, 3'd0, 0, 0, 16'h1234, 26'h1, 1, 32'h5, "R2");
        do_step(1, 3'd6, 1, 1, 16'h0040, 26'h2, 1, 32'h9, "R2");
        // stall: everything else is ignored
        do_step(0, 3'd1, 1, 1, 16'h0100, 26'h3, 1, 32'h7, "R3");
        do_step(0, 3'd3, 1, 0, 16'h0000, 26'h0, 0, 32'h1000, "R3");
        do_step(1, 3'd1, 0, 0, 16'h0010, 26'h0, 1, 32'h0, "R4");
        do_step(1, 3'd0, 0, 0, 16'h0000, 26'h0, 0, 32'h0, "R4");
        do_step(1, 3'd1, 0, 0, 16'hFFF0, 26'h0, 1, 32'h0, "R4");
        do_step(1, 3'd1, 0, 0, 16'h8000, 26'h0, 1, 32'h0, "R4");
        do_step(1, 3'd0, 0, 0, 16'h0000, 26'h0, 0, 32'h0, "R4");
        do_step(1, 3'd1, 0, 0, 16'h0020, 26'h0, 0, 32'h0, "R5");
        do_step(1, 3'd2, 0, 0, 16'h0008, 26'h0, 0, 32'h0, "R6");
        do_step(1, 3'd0, 0, 0, 16'h0000, 26'h0, 0, 32'h0, "R6");
        do_step(1, 3'd1, 0, 1, 16'h0030, 26'h0, 0, 32'h0, "R7");
        do_step(1, 3'd0, 0, 0, 16'h0000, 26'h0, 0, 32'h0, "R7");
        do_step(1, 3'd1, 0, 1, 16'h0030, 26'h0, 1, 32'h0, "R7");
        do_step(1, 3'd0, 0, 0, 16'h0000, 26'h0, 0, 32'h0, "R7");
        do_step(1, 3'd3, 0, 0, 16'h0000, 26'h0, 0, 32'h8000_1233, "R8");
        do_step(1, 3'd0, 0, 0, 16'h0000, 26'h0, 0, 32'h0, "R8");
        do_step(1, 3'd4, 0, 0, 16'h0000, 26'h2ABCDEF, 0, 32'h0, "R9");
        do_step(1, 3'd0, 0, 0, 16'h0000, 26'h0, 0, 32'h0, "R9");
        do_step(1, 3'd4, 1, 0, 16'h0000, 26'h3FFFFFF, 1, 32'h0, "R10");
        do_step(1, 3'd0, 0, 0, 16'h0000, 26'h0, 0, 32'h0, "R10");
        do_step(1, 3'd1, 1, 0, 16'h0044, 26'h0, 0, 32'h0, "R10");
        do_step(1, 3'd0, 1, 1, 16'h0044, 26'h0, 1, 32'h0, "R10");
        do_step(1, 3'd1, 1, 1, 16'h0044, 26'h0, 0, 32'h0, "R10");

        for (int i = 0; i < 400; i++) begin
            logic [2:0] k;
            k = 3'($urandom_range(0, 7));
            do_step(1'($urandom_range(0, 3) != 0), k, 1'($urandom),
                    1'($urandom), 16'($urandom), 26'($urandom), 1'($urandom),
                    $urandom, "R2 R4 R7 R8 R9 R10 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule